// File: doc/BRIEF.md
# Receive Cell Integrity Monitor

This block watches the byte stream of a cell receiver and raises status flags when something in that stream goes wrong. Four separate conditions are tracked. The first is a cell that the header checker reports as failing its HEC test. The second is a cell that is cut short, meaning the next start-of-cell marker arrives before a full cell's worth of bytes. The third is a line symbol that the decoder reports as undefined. The fourth is any change in the received signal-quality indication, whether it goes from good to bad or from bad to good. The HEC arithmetic and the symbol decoding happen upstream. This block receives only their per-cell and per-symbol verdicts.

Each condition latches into its own flag. A flag stays set until software writes one to that flag's clear strobe. A per-flag enable mask selects which flags drive the single interrupt line. Short cells are found by counting the accepted bytes between successive start-of-cell markers. The count saturates at one full cell, so a long gap cannot wrap the counter.

Top module: `rx_integrity_mon`

## Requirements
- R1: While reset is asserted and on its release, all four flags read 0 and `irq` is 0. Flag bit positions are: bit 0 HEC error, bit 1 short cell, bit 2 undefined symbol, bit 3 signal-condition change.
- R2: When `hecFail` is high at a clock edge, flag bit 0 reads 1 after that edge.
- R3: A byte accepted with `socMark` high is counted as byte 1 of a new cell. If it arrives after fewer than `CELL_BYTES` (default 53) accepted bytes since the previous marker, counting that marker's byte, flag bit 1 is set after that edge. After exactly `CELL_BYTES` or more bytes it is not set.
- R4: No short-cell flag is raised by the first start-of-cell marker after reset, however few bytes preceded it.
- R5: When `symValid` and `symUndef` are both high at an edge, flag bit 2 is set after that edge. `symUndef` with `symValid` low has no effect.
- R6: `sigGood` is registered. A change of the registered value, in either direction, sets flag bit 3 two edges after the input changes. The first registered samples after reset never count as a change.
- R7: Cycles with `byteValid` low are not counted. A `socMark` with `byteValid` low neither starts a cell nor triggers the short-cell check.
- R8: A high bit of `clrFlags` at an edge clears only the matching flag. Flags not being cleared hold their value.
- R9: If a flag's event and its clear strobe occur at the same edge, the flag ends up set.
- R10: `irq` is combinationally the OR of `flags & irqEnable`.
- R11: The byte counter saturates at `CELL_BYTES`. A gap of any length beyond one cell, including gaps past the counter's binary range, never raises the short-cell flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | A received byte is present this cycle |
| socMark | input | 1 | The present byte starts a cell |
| hecFail | input | 1 | One-cycle strobe: the current cell failed its HEC |
| symValid | input | 1 | A decoded line symbol is present this cycle |
| symUndef | input | 1 | The present symbol is undefined |
| sigGood | input | 1 | Received signal-quality level (1 = good) |
| clrFlags | input | 4 | Write-one-to-clear strobes, one per flag |
| irqEnable | input | 4 | Per-flag interrupt enables |
| flags | output | 4 | Sticky flags (bit 0 HEC, 1 short, 2 symbol, 3 signal) |
| irq | output | 1 | Combined interrupt |

## Verification
The HEC, symbol and short-cell flags are due one clock edge after the stimulus is sampled. The signal-condition flag is due two edges after `sigGood` changes, because the input first passes through a register. `irq` follows the flags and the enables within the same cycle. The bench drives inputs one time unit after a rising edge and reads results one time unit after the edge at which each result is due, so for the signal flag it checks after the first edge (still clear) and again after the second edge (set). The short-cell rule is swept over every gap length from 1 to 70 bytes, which takes the count past the counter's binary range. The enable mask is swept over all 16 values against two flag patterns.

// File: rtl/rxim_pkg.sv
package rxim_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int FLAG_HEC = 0;
  localparam int FLAG_SHORT = 1;
  localparam int FLAG_SYM = 2;
  localparam int FLAG_SIG = 3;

  typedef struct packed {
    logic sigChange;
    logic symErr;
    logic shortCell;
    logic hec;
  } evt_t;
endpackage

// File: rtl/rxim_ctrl.sv
module rxim_ctrl
  import rxim_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  localparam int CNT_W = $clog2(CELL_BYTES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic byteValid,
  input  logic socMark,
  input  logic hecFail,
  input  logic symValid,
  input  logic symUndef,
  input  logic sigGood,
  output evt_t evt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CELL_BYTES);

  logic [CNT_W-1:0] byteCnt;
  logic seenSoc;
  logic sigQ, sigP, arm1, arm2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      seenSoc <= 1'b0;
    end else if (byteValid) begin
      if (socMark) begin
        byteCnt <= CNT_W'(1);
        seenSoc <= 1'b1;
      end else if (byteCnt < FULL) begin
        byteCnt <= byteCnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sigQ <= 1'b0;
      sigP <= 1'b0;
      arm1 <= 1'b0;
      arm2 <= 1'b0;
    end else begin
      sigQ <= sigGood;
      sigP <= sigQ;
      arm1 <= 1'b1;
      arm2 <= arm1;
    end
  end

  always_comb begin
    evt.hec       = hecFail;
    evt.symErr    = symValid & symUndef;
    evt.shortCell = byteValid & socMark & seenSoc & (byteCnt < FULL);
    evt.sigChange = arm2 & (sigQ != sigP);
  end

  // R3
  soc_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && socMark |=> byteCnt == CNT_W'(1));

  // R11
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt <= FULL);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> $stable(byteCnt));

  // R6
  sig_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    arm2 && (sigGood != sigQ) |=> evt.sigChange);
endmodule

// File: rtl/rxim_flags.sv
module rxim_flags
  import rxim_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  evt_t                 evt,
  input  logic [NUM_FLAGS-1:0] clrFlags,
  output logic [NUM_FLAGS-1:0] flagsQ
);
  logic [NUM_FLAGS-1:0] evtVec;

  always_comb begin
    evtVec = '0;
    evtVec[FLAG_HEC]   = evt.hec;
    evtVec[FLAG_SHORT] = evt.shortCell;
    evtVec[FLAG_SYM]   = evt.symErr;
    evtVec[FLAG_SIG]   = evt.sigChange;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)          flagsQ[i] <= 1'b0;
      else if (evtVec[i]) flagsQ[i] <= 1'b1;
      else if (clrFlags[i]) flagsQ[i] <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtVec[i] |=> flagsQ[i]);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      clrFlags[i] && !evtVec[i] |=> !flagsQ[i]);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      flagsQ[i] && !clrFlags[i] |=> flagsQ[i]);
  end
endmodule

// File: rtl/rx_integrity_mon.sv
module rx_integrity_mon
  import rxim_pkg::*;
#(
  parameter int CELL_BYTES = 53
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       socMark,
  input  logic       hecFail,
  input  logic       symValid,
  input  logic       symUndef,
  input  logic       sigGood,
  input  logic [3:0] clrFlags,
  input  logic [3:0] irqEnable,
  output logic [3:0] flags,
  output logic       irq
);
  evt_t evt;
  logic [NUM_FLAGS-1:0] flagsQ;

  rxim_ctrl #(.CELL_BYTES(CELL_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .socMark(socMark),
    .hecFail(hecFail), .symValid(symValid), .symUndef(symUndef),
    .sigGood(sigGood), .evt(evt)
  );

  rxim_flags u_flags (
    .clk(clk), .rstN(rstN), .evt(evt), .clrFlags(clrFlags), .flagsQ(flagsQ)
  );

  assign flags = flagsQ;
  assign irq   = |(flagsQ & irqEnable);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> flags == '0);
endmodule

// File: tb/rx_integrity_mon_tb.sv
module rx_integrity_mon_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic byteValid = 0, socMark = 0, hecFail = 0, symValid = 0, symUndef = 0;
  logic sigGood = 1'b1;
  logic [3:0] clrFlags = '0, irqEnable = '0;
  logic [3:0] flags;
  logic irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rx_integrity_mon u_dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .socMark(socMark),
    .hecFail(hecFail), .symValid(symValid), .symUndef(symUndef),
    .sigGood(sigGood), .clrFlags(clrFlags), .irqEnable(irqEnable),
    .flags(flags), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic byteIn(logic soc);
    byteValid = 1'b1;
    socMark = soc;
    tick();
    byteValid = 1'b0;
    socMark = 1'b0;
  endtask

  task automatic clearPulse(logic [3:0] m);
    clrFlags = m;
    tick();
    clrFlags = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 flags in reset", flags, 4'h0);
    rstN = 1'b1;
    tick();
    irqEnable = 4'hF;
    #0;
    chk("R1 flags after release", flags, 4'h0);
    chk("R1 irq after release", irq, 1'b0);
    repeat (3) tick();
    chk("R6 no change on first samples", flags[3], 1'b0);

    // R4: bytes before first marker
    repeat (10) byteIn(1'b0);
    byteIn(1'b1);
    chk("R4 first marker", flags[1], 1'b0);

    // R3 / R11 sweep of gap length
    for (int n = 1; n <= 70; n++) begin
      clearPulse(4'b0010);
      repeat (n - 1) byteIn(1'b0);
      byteIn(1'b1);
      chk($sformatf("R3 R11 gap %0d", n), flags[1], (n < 53) ? 1'b1 : 1'b0);
    end

    // R7: invalid marker ignored, idle cycles not counted
    clearPulse(4'b0010);
    repeat (52) byteIn(1'b0);
    socMark = 1'b1;
    tick();
    socMark = 1'b0;
    byteIn(1'b1);
    chk("R7 marker without valid", flags[1], 1'b0);
    repeat (51) byteIn(1'b0);
    repeat (5) tick();
    byteIn(1'b1);
    chk("R7 idle not counted", flags[1], 1'b1);
    clearPulse(4'b0010);
    chk("R8 clear short", flags, 4'h0);

    // R2
    hecFail = 1'b1;
    tick();
    hecFail = 1'b0;
    chk("R2 hec", flags, 4'b0001);

    // R5 sweep
    for (int c = 0; c < 4; c++) begin
      symValid = c[1];
      symUndef = c[0];
      tick();
      symValid = 1'b0;
      symUndef = 1'b0;
      chk($sformatf("R5 sym combo %0d", c), flags[2], (c == 3) ? 1'b1 : 1'b0);
    end

    // R8
    clearPulse(4'b0001);
    chk("R8 clear only hec", flags, 4'b0100);
    // R9
    hecFail = 1'b1;
    clrFlags = 4'b0001;
    tick();
    hecFail = 1'b0;
    clrFlags = '0;
    chk("R9 set wins", flags, 4'b0101);

    // R6 both directions
    sigGood = 1'b0;
    tick();
    chk("R6 fall one edge", flags[3], 1'b0);
    tick();
    chk("R6 fall two edges", flags[3], 1'b1);
    clearPulse(4'b1000);
    chk("R8 clear sig", flags[3], 1'b0);
    sigGood = 1'b1;
    tick();
    chk("R6 rise one edge", flags[3], 1'b0);
    tick();
    chk("R6 rise two edges", flags[3], 1'b1);

    // short flag again to fill all four
    byteIn(1'b1);
    chk("R3 all flags set", flags, 4'hF);

    // R10 sweeps
    for (int e = 0; e < 16; e++) begin
      irqEnable = 4'(e);
      #1;
      chk($sformatf("R10 en %0d all", e), irq, (e != 0) ? 1'b1 : 1'b0);
    end
    clearPulse(4'b0101);
    chk("R8 partial clear", flags, 4'b1010);
    for (int e = 0; e < 16; e++) begin
      irqEnable = 4'(e);
      #1;
      chk($sformatf("R10 en %0d part", e), irq, ((e & 4'b1010) != 0) ? 1'b1 : 1'b0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule